// File: doc/BRIEF.md
# Channel Diagnostic Fault Latch

This block watches eight low-side output channels and turns what it sees into an 8-bit diagnostic word and one general fault indication. For every channel it takes the bit last written over the serial interface, the channel's effective on/off state (the serial bit possibly ORed with a direct parallel input), and a digital comparator result that is high while the drain voltage sits above the detection reference. From these it decides whether the channel is healthy, has an open load or short to ground (off with the drain low), or is overloaded (on with the drain high).

A suspect condition must hold, with the channel's on/off state unchanged, for a programmable number of system clock ticks before it counts as a fault. This filters switching transients. A confirmed fault is latched and stays until the serial interface sends its clear pulse at the end of a transfer. Each diagnostic bit reads as the written serial bit while the channel is healthy and as its inverse once a fault is latched. So a controller can compare what it wrote with what it reads back. Any latched fault drives an output-enable that pulls an open-drain, active-low interrupt line to ground. The open-load enable input is expected to carry a pull-up at the pad, so detection stays active when nothing drives it.

Top module: `diag_fault_latch`

## Requirements
- R1: While no fault is latched on a channel, its diagnostic bit equals that channel's serial command bit.
- R2: A channel that is off (ch_on=0) with drain_hi=0 while ol_en=1 is an open-load fault. Once latched, its diagnostic bit reads as the inverse of its serial bit, which is 1 for a serial bit of 0.
- R3: A channel that is on (ch_on=1) with drain_hi=1 is an overload fault. Once latched, its diagnostic bit reads as the inverse of its serial bit, which is 0 for a serial bit of 1.
- R4: A channel turned on only by its parallel input (serial bit 0, ch_on=1) reports 0 while healthy and 1 once an overload is latched.
- R5: While ol_en=0, an off channel with a low drain is never latched as a fault.
- R6: A fault latches at the FAULT_DLY-th consecutive clock edge at which the condition holds with an unchanged on/off state. If the condition drops at any edge first, the count starts again from zero.
- R7: A change in a channel's ch_on restarts that channel's count. A condition that persists across toggles of the state is therefore not latched until the state has been steady for FAULT_DLY edges after the toggle.
- R8: A latched fault stays latched after its condition goes away, until diag_clr is sampled high.
- R9: A diag_clr sampled high clears every latched fault at that edge and takes priority over a confirmation at the same edge. A fault whose condition persists latches again at the next edge.
- R10: fault_pull_en is 1 exactly while at least one channel holds a latched fault.
- R11: While rst_n is sampled low, all latched faults and counts are cleared, so fault_pull_en is 0 and diag_word equals spi_cmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cmd | input | NCH | Serial command bit per channel (bit 0 = channel 1) |
| ch_on | input | NCH | Effective on/off state per channel |
| drain_hi | input | NCH | Comparator: drain above detection reference |
| ol_en | input | 1 | Open-load / short-to-ground detection enable |
| diag_clr | input | 1 | One-cycle clear pulse from the serial interface |
| diag_word | output | NCH | Diagnostic word: spi_cmd XOR latched faults |
| fault_pull_en | output | 1 | Enable for the open-drain pull-down of the fault line |

## Verification
The assertions assume that ch_on, drain_hi, ol_en and diag_clr are already synchronous to clk. They also assume FAULT_DLY is at least 1, so the time since reset is the only history a property needs. The stimulus changes inputs only at the falling clock edge. It uses a short fault delay so that every debounce window, glitch and restart fits in a few cycles. Inputs are held stable across each rising edge, so the comparator and state inputs never change in the same cycle they are sampled.

// File: rtl/diag_fault_pkg.sv
// Package shared by the diagnostic fault latch: per-channel classification.
package diag_fault_pkg;
    typedef enum logic [1:0] {
        CH_OK   = 2'd0,   // channel healthy
        CH_OPEN = 2'd1,   // off with drain below reference
        CH_OVER = 2'd2    // on with drain above reference
    } ch_state_e;
endpackage

// File: rtl/diag_classify.sv
// Classifies one channel from its state and drain comparator.
// Assumes inputs are already synchronous to the system clock.
module diag_classify
    import diag_fault_pkg::*;
(
    input  logic      on_i,
    input  logic      drain_hi_i,
    input  logic      ol_en_i,
    output ch_state_e state_o
);
    // Decide the channel condition from state and comparator.
    always_comb begin
        state_o = CH_OK;
        if (on_i && drain_hi_i)
            state_o = CH_OVER;
        else if (!on_i && !drain_hi_i && ol_en_i)
            state_o = CH_OPEN;
    end
endmodule

// File: rtl/diag_debounce.sv
// Debounce counter and sticky latch for one channel.
// A fault latches after DLY consecutive edges with the condition present
// and the on/off state unchanged; clr wins over a same-edge confirmation.
// Assumes DLY >= 1.
module diag_debounce #(
    parameter int DLY = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic suspect_i,
    input  logic clr_i,
    output logic flag_o
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;
    logic          on_q;
    logic          steady;
    logic          confirm;

    // Condition qualifies only if the state did not just change.
    always_comb begin
        steady  = (on_i == on_q);
        confirm = suspect_i && steady && (cnt == LAST);
    end

    // Remember the last sampled on/off state.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= on_i;
    end

    // Count consecutive qualifying edges, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!suspect_i || !steady) cnt <= '0;
        else if (cnt != LAST)        cnt <= cnt + 1'b1;
    end

    // Sticky fault flag with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (clr_i)  flag_o <= 1'b0;
        else if (confirm) flag_o <= 1'b1;
    end
endmodule

// File: rtl/diag_fault_latch.sv
// Top: eight-channel diagnostic word and general fault pull-down enable.
// Each channel is classified, debounced and latched; diag bit = serial
// bit XOR latched fault. Assumes all inputs synchronous to clk.
module diag_fault_latch
    import diag_fault_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int FAULT_DLY = 12500
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] spi_cmd,
    input  logic [NCH-1:0] ch_on,
    input  logic [NCH-1:0] drain_hi,
    input  logic           ol_en,
    input  logic           diag_clr,
    output logic [NCH-1:0] diag_word,
    output logic           fault_pull_en
);
    logic [NCH-1:0] latched;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ch_state_e st;
        logic      suspect;

        diag_classify u_cls (
            .on_i       (ch_on[g]),
            .drain_hi_i (drain_hi[g]),
            .ol_en_i    (ol_en),
            .state_o    (st)
        );

        // Any non-healthy classification starts the debounce.
        always_comb suspect = (st != CH_OK);

        diag_debounce #(.DLY(FAULT_DLY)) u_deb (
            .clk       (clk),
            .rst_n     (rst_n),
            .on_i      (ch_on[g]),
            .suspect_i (suspect),
            .clr_i     (diag_clr),
            .flag_o    (latched[g])
        );
    end

    // Encode diagnostics and drive the shared fault pull-down.
    always_comb begin
        diag_word     = spi_cmd ^ latched;
        fault_pull_en = |latched;
    end
endmodule

// File: rtl/diag_fault_latch_chk.sv
// Checker bound to diag_fault_latch: temporal properties on ports and flags.
module diag_fault_latch_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] spi_cmd,
    input logic [NCH-1:0] ch_on,
    input logic [NCH-1:0] drain_hi,
    input logic           ol_en,
    input logic           diag_clr,
    input logic [NCH-1:0] diag_word,
    input logic           fault_pull_en,
    input logic [NCH-1:0] latched
);
    AST_HEALTHY_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_pull_en |-> (diag_word == spi_cmd)); // R1

    AST_OL_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((latched & ~$past(latched) & ~$past(ch_on) & ~$past(drain_hi)
          & ~{NCH{$past(ol_en)}}) == '0)); // R5

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_pull_en && !diag_clr) |=> fault_pull_en); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        diag_clr |=> !fault_pull_en); // R9

    AST_TOGGLE_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((latched & ~$past(latched) & ($past(ch_on) ^ $past(ch_on, 2))) == '0)); // R7
endmodule

bind diag_fault_latch diag_fault_latch_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_cmd       (spi_cmd),
    .ch_on         (ch_on),
    .drain_hi      (drain_hi),
    .ol_en         (ol_en),
    .diag_clr      (diag_clr),
    .diag_word     (diag_word),
    .fault_pull_en (fault_pull_en),
    .latched       (latched)
);

// File: tb/diag_fault_latch_test.sv
module diag_fault_latch_test;
    localparam int NCH = 8;
    localparam int DLY = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] spi_cmd = '0;
    logic [NCH-1:0] ch_on = '0;
    logic [NCH-1:0] drain_hi = '1;
    logic           ol_en = 1'b1;
    logic           diag_clr = 1'b0;
    logic [NCH-1:0] diag_word;
    logic           fault_pull_en;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R11";
    bit    done = 0;

    // reference model state
    int m_cnt [NCH];
    bit m_flag[NCH];
    bit m_prev[NCH];

    always #4 clk = ~clk;

    diag_fault_latch #(.NCH(NCH), .FAULT_DLY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cmd(spi_cmd), .ch_on(ch_on),
        .drain_hi(drain_hi), .ol_en(ol_en), .diag_clr(diag_clr),
        .diag_word(diag_word), .fault_pull_en(fault_pull_en)
    );

    // Behavioural reference: per-channel run length and sticky flag.
    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            bit bad;
            bit hit;
            hit = 0;
            if (!rst_n) begin
                m_cnt[i] = 0; m_flag[i] = 0; m_prev[i] = 0;
            end else begin
                bad = (ch_on[i] && drain_hi[i]) || (!ch_on[i] && !drain_hi[i] && ol_en);
                if (!bad || ch_on[i] != m_prev[i]) m_cnt[i] = 0;
                else if (m_cnt[i] + 1 >= DLY) hit = 1;
                else m_cnt[i] = m_cnt[i] + 1;
                if (diag_clr) m_flag[i] = 0;
                else if (hit) m_flag[i] = 1;
                m_prev[i] = ch_on[i];
            end
        end
    end

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    // One clock: rising edge, then compare model and design at the falling edge.
    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            logic [NCH-1:0] ew;
            bit ef;
            @(posedge clk);
            @(negedge clk);
            ef = 0;
            for (int i = 0; i < NCH; i++) begin
                ew[i] = spi_cmd[i] ^ m_flag[i];
                ef |= m_flag[i];
            end
            chk({tag, " diag_word"}, 32'(diag_word), 32'(ew));
            chk({tag, " fault_pull_en"}, 32'(fault_pull_en), 32'(ef));
        end
    endtask

    task automatic clear_pulse();
        diag_clr = 1'b1; tick(1); diag_clr = 1'b0;
    endtask

    task automatic healthy();
        spi_cmd = '0; ch_on = '0; drain_hi = '1; ol_en = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        tag = "R11"; rst_n = 1'b0; tick(3);
        chk("R11 reset fault", 32'(fault_pull_en), 0);
        rst_n = 1'b1;

        tag = "R1"; spi_cmd = 8'hA5; ch_on = 8'hA5; drain_hi = ~8'hA5; tick(10);
        chk("R1 echo", 32'(diag_word), 32'h A5);

        tag = "R2"; healthy(); tick(2); drain_hi[6] = 1'b0; tick(DLY - 1);
        chk("R2 not yet", 32'(diag_word[6]), 0);
        tick(1);
        chk("R2 open latched", 32'(diag_word[6]), 1);
        chk("R10 flag on", 32'(fault_pull_en), 1);
        tag = "R8"; drain_hi[6] = 1'b1; tick(4);
        chk("R8 held", 32'(diag_word[6]), 1);
        tag = "R9"; clear_pulse(); tick(2);
        chk("R9 cleared", 32'(fault_pull_en), 0);

        tag = "R3"; spi_cmd[0] = 1'b1; ch_on[0] = 1'b1; drain_hi[0] = 1'b0; tick(3);
        drain_hi[0] = 1'b1; tick(DLY + 1);
        chk("R3 overload", 32'(diag_word[0]), 0);
        healthy(); tick(1); clear_pulse(); tick(1);

        tag = "R4"; ch_on[2] = 1'b1; drain_hi[2] = 1'b0; tick(DLY + 3);
        chk("R4 healthy", 32'(diag_word[2]), 0);
        drain_hi[2] = 1'b1; tick(DLY + 1);
        chk("R4 overload", 32'(diag_word[2]), 1);
        healthy(); tick(1); clear_pulse(); tick(1);

        tag = "R5"; ol_en = 1'b0; drain_hi[5] = 1'b0; tick(3 * DLY);
        chk("R5 suppressed", 32'(fault_pull_en), 0);
        ol_en = 1'b1; tick(DLY + 1);
        chk("R2 after enable", 32'(diag_word[5]), 1);
        healthy(); tick(1); clear_pulse(); tick(1);

        tag = "R6"; spi_cmd[1] = 1'b1; ch_on[1] = 1'b1; drain_hi[1] = 1'b0; tick(2);
        for (int r = 0; r < 3; r++) begin
            drain_hi[1] = 1'b1; tick(DLY - 1);
            drain_hi[1] = 1'b0; tick(1);
        end
        chk("R6 glitches", 32'(fault_pull_en), 0);
        drain_hi[1] = 1'b1; tick(DLY);
        chk("R6 full window", 32'(diag_word[1]), 0);
        healthy(); tick(1); clear_pulse(); tick(1);

        tag = "R7";
        for (int r = 0; r < 4; r++) begin
            ch_on[3] = ~ch_on[3]; drain_hi[3] = ch_on[3]; tick(DLY - 1);
        end
        chk("R7 toggles", 32'(fault_pull_en), 0);
        tick(2);
        chk("R7 steady", 32'(diag_word[3]), 1);

        tag = "R9"; clear_pulse();
        chk("R9 clear wins", 32'(fault_pull_en), 0);
        tick(1);
        chk("R9 relatch", 32'(fault_pull_en), 1);
        healthy(); tick(2); clear_pulse(); tick(2);

        tag = "R11"; drain_hi[4] = 1'b0; tick(DLY + 1);
        rst_n = 1'b0; tick(1); rst_n = 1'b1; healthy();
        chk("R11 reset clears", 32'(fault_pull_en), 0);
        tick(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL all: watchdog expired, actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule